// File: doc/BRIEF.md
# Status and Error Interrupt Register

This block sits beside a serial-bus master's datapath and turns short event pulses from that datapath into sticky status flags that software can read. There are three flag groups. The transfer group holds the two "service needed" requests and the two "programmed word count reached" events. The buffer error group holds overrun and underrun of the transmit and receive buffers. The serial clock error group holds overrun and underrun of the bus clock. Each of the two error groups has its own enable register. Four live buffer-level bits are placed in the transfer register's read view, and software cannot change them.

Software reads a register through a one-cycle registered read port. To clear flags, it writes back the value it read: each 1 clears the flag at that position, and each 0 leaves its flag alone. A single level-high interrupt output is asserted while any enabled error flag is set, or while any transfer flag is set. Transfer flags always raise the interrupt and have no enable.

Top module: `stat_irq_regs`

## Requirements
- R1: After a synchronous reset, every flag and every enable is 0, `irq` is 0, and `rd_data` is 0.
- R2: A one-cycle pulse on `ev_buf_err[k]` sets a sticky flag, which reads back at address 1 bit k+2. The mapping is: k=0 receive overrun (bit 2), k=1 transmit underrun (bit 3), k=2 receive underrun (bit 4), k=3 transmit overrun (bit 5). The flag stays set after the pulse ends.
- R3: A one-cycle pulse on `ev_clk_err[k]` sets a sticky flag, which reads back at address 3 bit k. The mapping is: k=0 clock underrun (bit 0), k=1 clock overrun (bit 1).
- R4: A one-cycle pulse on `ev_xfer[k]` sets a sticky flag, which reads back at address 0 bit k+8. The mapping is: k=0 transmit service (bit 8), k=1 receive service (bit 9), k=2 transmit count done (bit 10), k=3 receive count done (bit 11).
- R5: A write to address 0, 1 or 3 clears each flag whose data bit is 1. Data bits that are 0 leave their flags unchanged.
- R6: When a flag's source pulse arrives in the same cycle as a write that clears that flag, the flag ends up set.
- R7: Address 2 (buffer error enables, bits 5:2) and address 4 (clock error enables, bits 1:0) are read/write, and their values read back as written.
- R8: `irq` is registered. It is 1 in the cycle after any buffer error flag that is set and enabled, any clock error flag that is set and enabled, or any set transfer flag. Otherwise it is 0.
- R9: Address 0 bits 7:4 show the `buf_level` input as it is at read time. Writes never change these bits.
- R10: `rd_data` shows the register selected by `rd_addr` one cycle after the address is applied. Bits outside a register's fields read 0, and addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write register index |
| wr_data | input | 32 | Write data (1 = clear for flag registers) |
| rd_addr | input | 3 | Read register index |
| rd_data | output | 32 | Registered read data |
| ev_xfer | input | 4 | Transfer event pulses |
| ev_buf_err | input | 4 | Buffer error pulses |
| ev_clk_err | input | 2 | Serial clock error pulses |
| buf_level | input | 4 | Live buffer status bits |
| irq | output | 1 | Level-high interrupt |

## Verification
Errors in a flag cell show up at the ports in two ways. The readback value of that register is wrong in the cycle after the read. Separately, `irq` gives the wrong level one cycle after the flag register changes. A flag that is lost, stuck, or cleared by a 0 data bit is therefore seen within two cycles of the pulse or the write. A fault in the enable mask shows only in `irq`, so the sweep pairs every error source with every enable pattern. A fault in the set-wins rule shows only when a pulse and a clear write land in the same cycle, so one case drives exactly that.

// File: rtl/stat_irq_pkg.sv
package stat_irq_pkg;
  localparam int ADDR_W   = 3;
  localparam int DATA_W   = 32;

  localparam int XFER_N   = 4;
  localparam int BUF_N    = 4;
  localparam int CLK_N    = 2;
  localparam int LVL_N    = 4;

  localparam int XFER_LSB = 8;
  localparam int LVL_LSB  = 4;
  localparam int BUF_LSB  = 2;
  localparam int CLK_LSB  = 0;

  typedef enum logic [ADDR_W-1:0] {
    A_XFER   = 3'd0,
    A_BUF    = 3'd1,
    A_BUF_EN = 3'd2,
    A_CLK    = 3'd3,
    A_CLK_EN = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/sticky_flags.sv
module sticky_flags #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flags_o
);
  for (genvar i = 0; i < W; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst)           flags_o[i] <= 1'b0;
      else if (set_i[i]) flags_o[i] <= 1'b1;
      else if (clr_i[i]) flags_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/enable_reg.sv
module enable_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst)       q_o <= '0;
    else if (ld_i) q_o <= d_i;
  end
endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
  parameter int XN = 4,
  parameter int BN = 4,
  parameter int CN = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [XN-1:0] xfer_f,
  input  logic [BN-1:0] buf_f,
  input  logic [BN-1:0] buf_en,
  input  logic [CN-1:0] clk_f,
  input  logic [CN-1:0] clk_en,
  output logic          irq_o
);
  logic pend;
  always_comb pend = (|xfer_f) | (|(buf_f & buf_en)) | (|(clk_f & clk_en));

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= pend;
  end
endmodule

// File: rtl/stat_irq_regs.sv
module stat_irq_regs
  import stat_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [XFER_N-1:0] ev_xfer,
  input  logic [BUF_N-1:0]  ev_buf_err,
  input  logic [CLK_N-1:0]  ev_clk_err,
  input  logic [LVL_N-1:0]  buf_level,
  output logic              irq
);
  logic [XFER_N-1:0] xfer_flags, xfer_clr;
  logic [BUF_N-1:0]  buf_flags, buf_clr, buf_en;
  logic [CLK_N-1:0]  clk_flags, clk_clr, clk_en;
  logic              ld_buf_en, ld_clk_en;

  always_comb begin
    xfer_clr  = (wr_en && wr_addr == A_XFER) ? wr_data[XFER_LSB +: XFER_N] : '0;
    buf_clr   = (wr_en && wr_addr == A_BUF)  ? wr_data[BUF_LSB +: BUF_N]   : '0;
    clk_clr   = (wr_en && wr_addr == A_CLK)  ? wr_data[CLK_LSB +: CLK_N]   : '0;
    ld_buf_en = wr_en && wr_addr == A_BUF_EN;
    ld_clk_en = wr_en && wr_addr == A_CLK_EN;
  end

  sticky_flags #(.W(XFER_N)) u_xfer (
    .clk(clk), .rst(rst), .set_i(ev_xfer), .clr_i(xfer_clr), .flags_o(xfer_flags));
  sticky_flags #(.W(BUF_N)) u_buf (
    .clk(clk), .rst(rst), .set_i(ev_buf_err), .clr_i(buf_clr), .flags_o(buf_flags));
  sticky_flags #(.W(CLK_N)) u_clk (
    .clk(clk), .rst(rst), .set_i(ev_clk_err), .clr_i(clk_clr), .flags_o(clk_flags));

  enable_reg #(.W(BUF_N)) u_buf_en (
    .clk(clk), .rst(rst), .ld_i(ld_buf_en), .d_i(wr_data[BUF_LSB +: BUF_N]), .q_o(buf_en));
  enable_reg #(.W(CLK_N)) u_clk_en (
    .clk(clk), .rst(rst), .ld_i(ld_clk_en), .d_i(wr_data[CLK_LSB +: CLK_N]), .q_o(clk_en));

  irq_merge #(.XN(XFER_N), .BN(BUF_N), .CN(CLK_N)) u_irq (
    .clk(clk), .rst(rst), .xfer_f(xfer_flags), .buf_f(buf_flags), .buf_en(buf_en),
    .clk_f(clk_flags), .clk_en(clk_en), .irq_o(irq));

  logic [DATA_W-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    case (rd_addr)
      A_XFER: begin
        rd_next[XFER_LSB +: XFER_N] = xfer_flags;
        rd_next[LVL_LSB +: LVL_N]   = buf_level;
      end
      A_BUF:    rd_next[BUF_LSB +: BUF_N] = buf_flags;
      A_BUF_EN: rd_next[BUF_LSB +: BUF_N] = buf_en;
      A_CLK:    rd_next[CLK_LSB +: CLK_N] = clk_flags;
      A_CLK_EN: rd_next[CLK_LSB +: CLK_N] = clk_en;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end
endmodule

// File: rtl/stat_irq_regs_chk.sv
module stat_irq_regs_chk
  import stat_irq_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [BUF_N-1:0]  ev_buf_err,
  input logic [CLK_N-1:0]  ev_clk_err,
  input logic [XFER_N-1:0] xfer_flags,
  input logic [BUF_N-1:0]  buf_flags,
  input logic [BUF_N-1:0]  buf_en,
  input logic [CLK_N-1:0]  clk_flags,
  input logic [CLK_N-1:0]  clk_en,
  input logic              irq
);
  a_r2_buf_pulse_sets: assert property (@(posedge clk) disable iff (rst)
    (ev_buf_err != '0) |=> ((buf_flags & $past(ev_buf_err)) == $past(ev_buf_err)));

  a_r3_clk_pulse_sets: assert property (@(posedge clk) disable iff (rst)
    (ev_clk_err != '0) |=> ((clk_flags & $past(ev_clk_err)) == $past(ev_clk_err)));

  a_r5_buf_hold_without_write: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_addr == A_BUF) |=> ((buf_flags & $past(buf_flags)) == $past(buf_flags)));

  a_r8_xfer_raises_irq: assert property (@(posedge clk) disable iff (rst)
    (xfer_flags != '0) |=> irq);

  a_r8_enabled_err_raises_irq: assert property (@(posedge clk) disable iff (rst)
    (((buf_flags & buf_en) != '0) || ((clk_flags & clk_en) != '0)) |=> irq);

  a_r8_quiet_irq: assert property (@(posedge clk) disable iff (rst)
    ((xfer_flags == '0) && ((buf_flags & buf_en) == '0) && ((clk_flags & clk_en) == '0))
      |=> !irq);
endmodule

bind stat_irq_regs stat_irq_regs_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
  .ev_buf_err(ev_buf_err), .ev_clk_err(ev_clk_err),
  .xfer_flags(xfer_flags), .buf_flags(buf_flags), .buf_en(buf_en),
  .clk_flags(clk_flags), .clk_en(clk_en), .irq(irq));

// File: tb/stat_irq_regs_test.sv
module stat_irq_regs_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [3:0]  ev_xfer = '0;
  logic [3:0]  ev_buf_err = '0;
  logic [1:0]  ev_clk_err = '0;
  logic [3:0]  buf_level = '0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  stat_irq_regs uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ev_xfer(ev_xfer), .ev_buf_err(ev_buf_err),
    .ev_clk_err(ev_clk_err), .buf_level(buf_level), .irq(irq));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic do_read(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); rd_addr = a;
    @(negedge clk); v = rd_data;
  endtask

  task automatic do_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got 0x0 expected 0x1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    for (int a = 0; a < 5; a++) begin
      do_read(a[2:0], v);
      check("R1 reg", v, 32'h0);
    end

    // R2 R5 R7 R8: each buffer error against every enable pattern
    for (int k = 0; k < 4; k++) begin
      for (int e = 0; e < 16; e++) begin
        do_write(3'd2, 32'(e) << 2);
        do_read(3'd2, v);
        check("R7 buf enable", v, 32'(e) << 2);
        @(negedge clk); ev_buf_err = 4'(1 << k);
        @(negedge clk); ev_buf_err = '0;
        settle();
        check("R8 buf irq", {31'b0, irq}, {31'b0, e[k]});
        do_read(3'd1, v);
        check("R2 buf flag", v, 32'(1) << (k + 2));
        do_write(3'd1, ~(32'(1) << (k + 2)));
        do_read(3'd1, v);
        check("R5 zero no effect", v, 32'(1) << (k + 2));
        do_write(3'd1, 32'(1) << (k + 2));
        settle();
        check("R8 irq drops", {31'b0, irq}, 32'h0);
        do_read(3'd1, v);
        check("R5 buf cleared", v, 32'h0);
      end
    end
    do_write(3'd2, 32'h0);

    // R3 R8: clock errors
    for (int k = 0; k < 2; k++) begin
      for (int e = 0; e < 4; e++) begin
        do_write(3'd4, 32'(e));
        do_read(3'd4, v);
        check("R7 clk enable", v, 32'(e));
        @(negedge clk); ev_clk_err = 2'(1 << k);
        @(negedge clk); ev_clk_err = '0;
        settle();
        check("R8 clk irq", {31'b0, irq}, {31'b0, e[k]});
        do_read(3'd3, v);
        check("R3 clk flag", v, 32'(1) << k);
        do_write(3'd3, 32'(1) << k);
        do_read(3'd3, v);
        check("R5 clk cleared", v, 32'h0);
      end
    end
    do_write(3'd4, 32'h0);
    settle();

    // R4 R8 R9: transfer flags raise irq with no enables
    buf_level = 4'hA;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); ev_xfer = 4'(1 << k);
      @(negedge clk); ev_xfer = '0;
      settle();
      check("R8 xfer irq", {31'b0, irq}, 32'h1);
      do_read(3'd0, v);
      check("R4 xfer flag", v, (32'(1) << (k + 8)) | 32'hA0);
      do_write(3'd0, 32'hFFF);
      do_read(3'd0, v);
      check("R9 live kept", v, 32'hA0);
      check("R8 xfer irq low", {31'b0, irq}, 32'h0);
    end
    buf_level = 4'h5;
    do_read(3'd0, v);
    check("R9 live follows", v, 32'h50);
    buf_level = 4'h0;

    // R6 set wins over clear in the same cycle
    @(negedge clk); ev_buf_err = 4'h1;
    @(negedge clk); ev_buf_err = '0;
    @(negedge clk); ev_buf_err = 4'h1; wr_en = 1'b1; wr_addr = 3'd1; wr_data = 32'h4;
    @(negedge clk); ev_buf_err = '0; wr_en = 1'b0; wr_data = '0;
    do_read(3'd1, v);
    check("R6 set wins", v, 32'h4);
    do_write(3'd1, 32'h4);

    // R10 unused addresses read zero, registered timing
    for (int a = 5; a < 8; a++) begin
      do_read(a[2:0], v);
      check("R10 unused addr", v, 32'h0);
    end
    do_write(3'd4, 32'h3);
    @(negedge clk); rd_addr = 3'd4;
    check("R10 one cycle latency", rd_data, 32'h0);
    @(negedge clk);
    check("R10 read data", rd_data, 32'h3);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule